// File: doc/BRIEF.md
# Printer-Style Parallel Port Host Registers

This block is the host side of a classic byte-wide printer port. A small CPU bus reaches three byte registers at offsets 0 to 2. The first register holds the data byte that goes out on the pins. The second returns the printer status lines. The third holds the handshake lines, the interrupt enable and the data-direction switch. Writes land on a clock edge when `wr_i` is high. Reads are captured into `rdata_o` on a clock edge when `rd_i` is high.

On the pin side the block drives an 8-bit data bus with an output enable. It also drives four handshake lines as open-drain pull-down requests and takes in five status lines. Each pin input passes through a two-flop synchronizer. Reads of the data and control registers return the synchronized pin levels, not the stored values. Software can therefore see when a device holds a released control line low, or, with the drivers off, read a byte driven from outside. A rising edge on the acknowledge line raises a one-cycle interrupt pulse while the interrupt enable is set.

Top module: `pp_port_regs`

## Requirements
- R1: After reset, `pd_o` is 0x00, `pd_oe_o` is 1, `irq_o` is 0, and the control register holds 0x0C. The reset control value makes `ctl_pull_low_o` equal 4'b1000.
- R2: A write to offset 0 sets `pd_o` to the written byte from the next cycle on. Writes to offsets 1 and 3 leave `pd_o` and the control register unchanged.
- R3: A write to offset 2 stores bits 5..0. From the next cycle, `ctl_pull_low_o[0]`, `[1]` and `[3]` equal control bits 0, 1 and 3, and `ctl_pull_low_o[2]` equals the inverse of control bit 2. A pin level is therefore the inverse of bits 0, 1 and 3 and equal to bit 2.
- R4: Control bit 5 set to 1 drives `pd_oe_o` to 0 (data tristated). Bit 5 set to 0 drives it to 1.
- R5: A read of offset 0 returns the `pd_i` pin levels, sampled two cycles after the pins change. With the drivers on, this equals the data latch. With the drivers off, it equals the externally driven byte.
- R6: A read of offset 2 returns the following:
  - bits 0, 1 and 3 as the inverse of `ctl_i[0]`, `ctl_i[1]` and `ctl_i[3]`;
  - bit 2 as `ctl_i[2]`;
  - bit 4 as the stored interrupt enable;
  - bits 7..5 as 1.
- R7: A read of offset 1 returns bits 7..3 as {~stat_i[4], stat_i[3], stat_i[2], stat_i[1], stat_i[0]}, and bits 2..0 as 1.
- R8: With control bit 4 set, a rising edge on `stat_i[3]` (acknowledge) gives a single-cycle `irq_o` pulse 3 clock edges later. A falling edge gives no pulse, and a rising edge gives none while bit 4 is 0.
- R9: `rdata_o` changes only on a clock edge where `rd_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_o | output | 1 | Interrupt pulse |
| pd_o | output | 8 | Data pins, output value |
| pd_oe_o | output | 1 | Data pin output enable |
| pd_i | input | 8 | Data pin levels |
| ctl_pull_low_o | output | 4 | Open-drain pull-down request per control line |
| ctl_i | input | 4 | Control pin levels |
| stat_i | input | 5 | Status pins {busy, ack, paper_end, select_in, error}; index k is status bit k+3 |

## Verification
Register writes show on `pd_o`, `pd_oe_o` and `ctl_pull_low_o` one edge after the write strobe. The bench drives at the falling edge and compares at the next falling edge. Pin changes need two edges to pass the synchronizer, so the bench waits three edges before it issues a read. The read value then appears one edge after `rd_i`. The interrupt pulse is due exactly three edges after the acknowledge pin rises, and the bench checks that it is high in that cycle and low in the next.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int SW = 5;
  localparam int AW = 2;

  localparam logic [AW-1:0] OFS_DATA = 2'd0;
  localparam logic [AW-1:0] OFS_STAT = 2'd1;
  localparam logic [AW-1:0] OFS_CTRL = 2'd2;

  typedef struct packed {
    logic dir_in;
    logic irq_en;
    logic sel;
    logic init;
    logic afd;
    logic stb;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE = '{dir_in: 1'b0, irq_en: 1'b0, sel: 1'b1,
                                  init: 1'b1, afd: 1'b0, stb: 1'b0};

  // register bit -> pin level polarity: 1 means inverted
  localparam logic [CW-1:0] CTL_INV = 4'b1011;
  localparam logic [SW-1:0] STAT_INV = 5'b10000;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pp_edge_irq.sv
module pp_edge_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_s_i,
  input  logic irq_en_i,
  output logic irq_o
);
  logic ack_d_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_d_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ack_d_q <= ack_s_i;
      irq_q   <= ack_s_i & ~ack_d_q & irq_en_i;
    end
  end

  assign irq_o = irq_q;

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i));
  assert_irq_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  assert_irq_on_rise_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ack_s_i));
endmodule

// File: rtl/pp_reg_bank.sv
module pp_reg_bank
  import pp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] pd_s_i,
  input  logic [CW-1:0] ctl_s_i,
  input  logic [SW-1:0] stat_s_i,
  output logic [DW-1:0] data_o,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] rdata_o
);
  localparam int SLO = DW - SW;
  localparam int CHI = DW - CW - 1;

  logic [DW-1:0] data_q, rdata_q, rd_mux;
  ctrl_t         ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      ctrl_q <= CTRL_IDLE;
    end else if (wr_i) begin
      if (addr_i == OFS_DATA) data_q <= wdata_i;
      if (addr_i == OFS_CTRL) ctrl_q <= ctrl_t'(wdata_i[5:0]);
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_DATA: rd_mux = pd_s_i;
      OFS_STAT: rd_mux = {stat_s_i ^ STAT_INV, {SLO{1'b1}}};
      OFS_CTRL: rd_mux = {{(CHI){1'b1}}, ctrl_q.irq_en, ctl_s_i ^ CTL_INV};
      default:  rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign data_o  = data_q;
  assign ctrl_o  = ctrl_q;
  assign rdata_o = rdata_q;

  assert_data_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_DATA) |=> data_o == $past(wdata_i));
  assert_data_ignore_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && addr_i == OFS_DATA)) |=> $stable(data_o));
  assert_ctrl_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CTRL) |=> ctrl_o == ctrl_t'($past(wdata_i[5:0])));
  assert_stat_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == OFS_STAT) |=> rdata_o[SLO-1:0] == '1);
  assert_rdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/pp_port_regs.sv
module pp_port_regs
  import pp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic [DW-1:0] pd_o,
  output logic          pd_oe_o,
  input  logic [DW-1:0] pd_i,
  output logic [CW-1:0] ctl_pull_low_o,
  input  logic [CW-1:0] ctl_i,
  input  logic [SW-1:0] stat_i
);
  localparam int PW = DW + CW + SW;
  localparam int ACK_IDX = 3;

  logic [PW-1:0] pins_s;
  logic [DW-1:0] pd_s, data_q;
  logic [CW-1:0] ctl_s, ctl_bits;
  logic [SW-1:0] stat_s;
  ctrl_t         ctrl_q;

  pp_sync #(.W(PW), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({stat_i, ctl_i, pd_i}),
    .q_o   (pins_s)
  );

  assign {stat_s, ctl_s, pd_s} = pins_s;

  pp_reg_bank u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .wdata_i (wdata_i),
    .pd_s_i  (pd_s),
    .ctl_s_i (ctl_s),
    .stat_s_i(stat_s),
    .data_o  (data_q),
    .ctrl_o  (ctrl_q),
    .rdata_o (rdata_o)
  );

  pp_edge_irq u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_s_i (stat_s[ACK_IDX]),
    .irq_en_i(ctrl_q.irq_en),
    .irq_o   (irq_o)
  );

  assign ctl_bits = {ctrl_q.sel, ctrl_q.init, ctrl_q.afd, ctrl_q.stb};
  // pull low whenever the intended pin level is 0
  assign ctl_pull_low_o = ~(ctl_bits ^ CTL_INV);
  assign pd_o    = data_q;
  assign pd_oe_o = ~ctrl_q.dir_in;

  assert_tristate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CTRL) |=> pd_oe_o == !$past(wdata_i[5]));
  assert_ctl_pins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CTRL) |=>
      ctl_pull_low_o == {$past(wdata_i[3]), !$past(wdata_i[2]), $past(wdata_i[1:0])});
endmodule

// File: tb/pp_port_regs_tb.sv
module pp_port_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;
  logic [7:0] pd_o, pd_pin, ext_pd = 8'h00;
  logic       pd_oe;
  logic [3:0] pull_low, ctl_pin, ext_low = 4'h0;
  logic [4:0] stat = 5'b0;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign pd_pin  = pd_oe ? pd_o : ext_pd;
  assign ctl_pin = ~(pull_low | ext_low);

  pp_port_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .pd_o(pd_o), .pd_oe_o(pd_oe),
    .pd_i(pd_pin), .ctl_pull_low_o(pull_low), .ctl_i(ctl_pin), .stat_i(stat)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    @(posedge clk); @(negedge clk);
    rd = 1'b0; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] exp_pull(input logic [7:0] c);
    return {c[3], ~c[2], c[1], c[0]};
  endfunction

  function automatic logic [7:0] exp_ctrl_rd(input logic [3:0] pin, input logic ien);
    return {3'b111, ien, ~pin[3], pin[2], ~pin[1], ~pin[0]};
  endfunction

  function automatic logic [7:0] exp_stat_rd(input logic [4:0] s);
    return {~s[4], s[3:0], 3'b111};
  endfunction

  initial begin
    #200_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] r, c, d, hold;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pd_o", pd_o, 8'h00);
    chk("R1 oe", {7'b0, pd_oe}, 8'h01);
    chk("R1 pull_low", {4'b0, pull_low}, 8'h08);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    settle();
    rd_reg(2'd2, r);
    chk("R1 ctrl rd", r, 8'hEC);

    // R2 writes and ignored offsets
    wr_reg(2'd0, 8'hA5);
    chk("R2 pd_o", pd_o, 8'hA5);
    wr_reg(2'd1, 8'h3C);
    wr_reg(2'd3, 8'hFF);
    chk("R2 ignore pd_o", pd_o, 8'hA5);
    chk("R2 ignore ctrl", {4'b0, pull_low}, 8'h08);
    chk("R2 ignore oe", {7'b0, pd_oe}, 8'h01);

    // R9 rdata hold without rd
    rd_reg(2'd0, hold);
    stat = 5'b10101;
    settle();
    chk("R9 hold", rdata, hold);

    // R5 tristate readback of external byte
    ext_pd = 8'h5A;
    wr_reg(2'd2, 8'h2C);
    chk("R4 oe off", {7'b0, pd_oe}, 8'h00);
    settle();
    rd_reg(2'd0, r);
    chk("R5 ext byte", r, 8'h5A);

    // R6 external pull on released line
    wr_reg(2'd2, 8'h04);
    ext_low = 4'b0001;
    settle();
    rd_reg(2'd2, r);
    chk("R6 ext pull", r, exp_ctrl_rd(4'b1110, 1'b0));
    ext_low = 4'b0000;

    // R8 interrupt on rising ack
    stat = 5'b00000;
    wr_reg(2'd2, 8'h1C);
    settle();
    stat[3] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 irq pulse", {7'b0, irq}, 8'h01);
    @(negedge clk);
    chk("R8 irq single", {7'b0, irq}, 8'h00);
    stat[3] = 1'b0;
    repeat (5) begin
      @(negedge clk);
      chk("R8 no irq on fall", {7'b0, irq}, 8'h00);
    end
    wr_reg(2'd2, 8'h0C);
    stat[3] = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk("R8 no irq disabled", {7'b0, irq}, 8'h00);
    end

    // random mix
    for (int i = 0; i < 60; i++) begin
      d = 8'($urandom);
      c = 8'($urandom) & 8'hEF;
      ext_pd = 8'($urandom);
      ext_low = 4'($urandom) & 4'($urandom);
      stat = 5'($urandom);
      wr_reg(2'd0, d);
      chk("R2 pd_o", pd_o, d);
      wr_reg(2'd2, c);
      chk("R3 pull_low", {4'b0, pull_low}, {4'b0, exp_pull(c)});
      chk("R4 oe", {7'b0, pd_oe}, {7'b0, ~c[5]});
      settle();
      rd_reg(2'd0, r);
      chk("R5 data rd", r, c[5] ? ext_pd : d);
      rd_reg(2'd1, r);
      chk("R7 stat rd", r, exp_stat_rd(stat));
      rd_reg(2'd2, r);
      chk("R6 ctrl rd", r, exp_ctrl_rd(~(exp_pull(c) | ext_low), c[4]));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule